// File: doc/BRIEF.md
# Event Timer Register Front End

This block is the register-facing side of a multi-channel event timer. A simple single-cycle port carries 32-bit or 64-bit little-endian accesses into a 1 KiB register window. The block keeps the global registers itself: a read-only capability word built from parameters, a two-bit configuration register, an interrupt status register that software clears by writing ones, and the 64-bit main counter. The main counter advances by one on every cycle in which `tick_en` is high while the block is enabled, and it holds its value while halted.

Accesses that fall in the per-channel part of the window are decoded into a one-hot channel select and a register code. The write data and lane mask go out already shifted into place, and the channel returns its read data on a flat bus. Each channel reports level events on `ch_hit`, which set its status bit. Comparator logic, interrupt pin routing and any bus fabric live outside this block.

Top module: `evt_regs`

## Requirements
- R1: The capability word at offset 0x000 reads as: bits 7:0 = 1, bits 12:8 = NUM_TIMERS-1, bit 13 = 1 (64-bit counter), bit 15 = 1 (legacy routing capable), bits 31:16 = VENDOR_ID, bits 63:32 = tick period in femtoseconds (TICK_FS). Writes to it change nothing.
- R2: The configuration register at 0x010 has two writable bits: bit 0 is the run enable and bit 1 is legacy routing. Every other bit reads as 0 whatever is written.
- R3: With `acc_size` = 2'b11 an access is 8 bytes, and any other code means 4 bytes. An access with address bit 2 set, or any 4-byte access, covers 32 bits. With address bit 2 set, write data bits 31:0 land in register bits 63:32, and a read returns register bits 63:32 in `rd_data[31:0]`. Bits 63:32 of a 32-bit read are 0.
- R4: While enabled, the main counter (offset 0x0F0) rises by exactly one on each cycle with `tick_en` high and holds on cycles with `tick_en` low. While halted it does not move.
- R5: Clearing the enable bit freezes the counter at its live value. Setting the enable bit resumes counting from the stored value.
- R6: A counter write while halted loads the addressed lanes. A counter write while enabled leaves the running count and the value read back unchanged.
- R7: A `ch_hit[n]` pulse sets status bit n (offset 0x020). Writing a 1 to a status bit clears it, writing 0 leaves it, and a hit in the same cycle as a clear wins.
- R8: Offset 0x100 + n*0x20 + k*8, with k = 0 (config), 1 (comparator) or 2 (route) and n < NUM_TIMERS, asserts `ch_sel[n]` with `ch_reg` = k. It forwards the lane-placed data and mask, and a read returns the channel's `ch_rdata` slice.
- R9: A channel index of NUM_TIMERS or above, k = 3, an unlisted global offset, or an address with bits 1:0 not zero is ignored. Such an access raises no `ch_sel`, changes no register, and reads as 0.
- R10: After reset the configuration, status and main counter are 0 and `rd_valid` is low.
- R11: `rd_valid` and `rd_data` are updated on the clock edge that accepts a read, so they appear one cycle after the request. `rd_valid` is low after a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Counter advance enable |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 10 | Byte offset in the window |
| acc_size | input | 2 | 2'b11 = 8 bytes, else 4 bytes |
| acc_wdata | input | 64 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 64 | Read data |
| ch_sel | output | NUM_TIMERS | One-hot channel select |
| ch_reg | output | 2 | Channel register code |
| ch_we | output | 1 | Channel write strobe |
| ch_wdata | output | 64 | Lane-placed write data |
| ch_wmask | output | 64 | Written lane mask |
| ch_rdata | input | NUM_TIMERS*64 | Channel read data, channel n at bits n*64+63:n*64 |
| ch_hit | input | NUM_TIMERS | Per-channel level event |
| irq_status | output | NUM_TIMERS | Interrupt status bits |
| cnt_run | output | 1 | Configuration run enable |
| legacy_route | output | 1 | Configuration legacy routing bit |
| main_count | output | 64 | Current main counter value |

## Verification
The counter is tried under four patterns: halted, enabled with `tick_en` held low, enabled with a counted burst of ticks, and enable toggled around writes. Together they separate "frozen", "resumed from stored value" and "write ignored while running". Register accesses are tried in 64-bit form, as 32-bit lower halves and as 32-bit upper halves, so that a lane placement or read-shift error shows up as a swapped or unmasked half. Status clearing uses one-bit and zero-value masks, plus a hit in the same cycle as a clear, to tell W1C apart from plain write and from the wrong priority. Out-of-range channels, reserved register codes, unlisted offsets and misaligned addresses are checked against the select strobe and against unchanged read-back.

// File: rtl/evt_regs_pkg.sv
package evt_regs_pkg;

  typedef enum logic [2:0] {
    TGT_NONE = 3'd0,
    TGT_CAP  = 3'd1,
    TGT_CFG  = 3'd2,
    TGT_STS  = 3'd3,
    TGT_CNT  = 3'd4,
    TGT_CHAN = 3'd5
  } tgt_e;

  // Mask of register bits covered by an access.
  function automatic logic [63:0] lane_mask(input logic hi, input logic wide);
    if (hi)        return {32'hFFFF_FFFF, 32'h0};
    else if (wide) return 64'hFFFF_FFFF_FFFF_FFFF;
    else           return {32'h0, 32'hFFFF_FFFF};
  endfunction

  // Move bus data into register position.
  function automatic logic [63:0] lane_place(input logic [63:0] d, input logic hi);
    return hi ? {d[31:0], 32'h0} : d;
  endfunction

  // Move register value onto the read bus.
  function automatic logic [63:0] lane_extract(input logic [63:0] v, input logic hi,
                                               input logic wide);
    if (hi)        return {32'h0, v[63:32]};
    else if (wide) return v;
    else           return {32'h0, v[31:0]};
  endfunction

  function automatic logic [63:0] lane_merge(input logic [63:0] old_v,
                                             input logic [63:0] new_v,
                                             input logic [63:0] m);
    return (new_v & m) | (old_v & ~m);
  endfunction

  function automatic logic [63:0] cap_word(input int unsigned ntim,
                                           input logic [15:0] vendor,
                                           input logic [31:0] period_fs);
    logic [4:0] last_idx;
    last_idx = 5'(ntim - 1);
    return {period_fs, vendor, 1'b1, 1'b0, 1'b1, last_idx, 8'h01};
  endfunction

endpackage

// File: rtl/evt_addr_decode.sv
module evt_addr_decode
  import evt_regs_pkg::*;
#(
  parameter int NUM_TIMERS = 3
) (
  input  logic [9:0] addr,
  output tgt_e       tgt,
  output logic [4:0] ch_idx,
  output logic [1:0] ch_reg,
  output logic       hi_half
);
  localparam logic [4:0] CH_BASE = 5'd8;  // 0x100 >> 5
  localparam logic [4:0] CH_LIMIT = 5'(NUM_TIMERS);

  logic aligned;
  logic in_global;

  assign aligned   = (addr[1:0] == 2'b00);
  assign in_global = (addr[9:8] == 2'b00);
  assign hi_half   = addr[2];
  assign ch_idx    = addr[9:5] - CH_BASE;
  assign ch_reg    = addr[4:3];

  always_comb begin
    tgt = TGT_NONE;
    if (aligned) begin
      if (in_global) begin
        unique case (addr[7:3])
          5'h00:   tgt = TGT_CAP;
          5'h02:   tgt = TGT_CFG;
          5'h04:   tgt = TGT_STS;
          5'h1E:   tgt = TGT_CNT;
          default: tgt = TGT_NONE;
        endcase
      end else if ((ch_idx < CH_LIMIT) && (ch_reg != 2'd3)) begin
        tgt = TGT_CHAN;
      end
    end
  end
endmodule

// File: rtl/evt_main_counter.sv
module evt_main_counter
  import evt_regs_pkg::*;
#(
  parameter int CW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tick_en,
  input  logic          en_rise,
  input  logic          en_fall,
  input  logic          wr_en,
  input  logic [CW-1:0] wdata,
  input  logic [CW-1:0] wmask,
  output logic [CW-1:0] value
);
  logic [CW-1:0] stored_q;
  logic [CW-1:0] live_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stored_q <= '0;
    end else if (en_fall) begin
      stored_q <= live_q;
    end else if (wr_en) begin
      stored_q <= (wdata & wmask) | (stored_q & ~wmask);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= '0;
    end else if (en_rise) begin
      live_q <= stored_q;
    end else if (run && tick_en) begin
      live_q <= live_q + CW'(1);
    end
  end

  assign value = run ? live_q : stored_q;
endmodule

// File: rtl/evt_global_regs.sv
module evt_global_regs #(
  parameter int NUM_TIMERS = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [1:0]            cfg_wbits,
  input  logic [1:0]            cfg_wmask,
  input  logic                  sts_we,
  input  logic [NUM_TIMERS-1:0] sts_wbits,
  input  logic [NUM_TIMERS-1:0] sts_wmask,
  input  logic [NUM_TIMERS-1:0] ch_hit,
  output logic [1:0]            cfg,
  output logic [NUM_TIMERS-1:0] status,
  output logic                  en_rise,
  output logic                  en_fall,
  output logic [NUM_TIMERS-1:0] w1c_bits
);
  logic [1:0] cfg_q, cfg_next;
  logic [NUM_TIMERS-1:0] sts_q;

  assign cfg_next = cfg_we ? ((cfg_wbits & cfg_wmask) | (cfg_q & ~cfg_wmask)) : cfg_q;
  assign en_rise  = !cfg_q[0] && cfg_next[0];
  assign en_fall  = cfg_q[0] && !cfg_next[0];
  assign w1c_bits = sts_we ? (sts_wbits & sts_wmask) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      sts_q <= '0;
    end else begin
      cfg_q <= cfg_next;
      sts_q <= (sts_q & ~w1c_bits) | ch_hit;
    end
  end

  assign cfg    = cfg_q;
  assign status = sts_q;
endmodule

// File: rtl/evt_regs.sv
module evt_regs
  import evt_regs_pkg::*;
#(
  parameter int          NUM_TIMERS = 3,
  parameter logic [15:0] VENDOR_ID  = 16'hA5C3,
  parameter logic [31:0] TICK_FS    = 32'd10_000_000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tick_en,
  input  logic                     acc_valid,
  input  logic                     acc_write,
  input  logic [9:0]               acc_addr,
  input  logic [1:0]               acc_size,
  input  logic [63:0]              acc_wdata,
  output logic                     rd_valid,
  output logic [63:0]              rd_data,
  output logic [NUM_TIMERS-1:0]    ch_sel,
  output logic [1:0]               ch_reg,
  output logic                     ch_we,
  output logic [63:0]              ch_wdata,
  output logic [63:0]              ch_wmask,
  input  logic [NUM_TIMERS*64-1:0] ch_rdata,
  input  logic [NUM_TIMERS-1:0]    ch_hit,
  output logic [NUM_TIMERS-1:0]    irq_status,
  output logic                     cnt_run,
  output logic                     legacy_route,
  output logic [63:0]              main_count
);
  localparam logic [63:0] CAP_VALUE = cap_word(NUM_TIMERS, VENDOR_ID, TICK_FS);

  tgt_e       tgt;
  logic [4:0] dec_idx;
  logic [1:0] dec_reg;
  logic       hi_half;
  logic       wide;
  logic [63:0] wr_placed, wr_mask;

  // Named events for the checker.
  logic cfg_wr_evt, cnt_wr_evt, w1c_evt, bad_acc;
  logic [NUM_TIMERS-1:0] w1c_bits;
  logic en_rise, en_fall;
  logic [1:0] cfg;

  evt_addr_decode #(.NUM_TIMERS(NUM_TIMERS)) dec_i (
    .addr    (acc_addr),
    .tgt     (tgt),
    .ch_idx  (dec_idx),
    .ch_reg  (dec_reg),
    .hi_half (hi_half)
  );

  assign wide      = (acc_size == 2'b11);
  assign wr_placed = lane_place(acc_wdata, hi_half);
  assign wr_mask   = lane_mask(hi_half, wide);

  assign cfg_wr_evt = acc_valid && acc_write && (tgt == TGT_CFG);
  assign cnt_wr_evt = acc_valid && acc_write && (tgt == TGT_CNT);
  assign w1c_evt    = acc_valid && acc_write && (tgt == TGT_STS);
  assign bad_acc    = acc_valid && (tgt == TGT_NONE);

  evt_global_regs #(.NUM_TIMERS(NUM_TIMERS)) glb_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_wr_evt),
    .cfg_wbits (wr_placed[1:0]),
    .cfg_wmask (wr_mask[1:0]),
    .sts_we    (w1c_evt),
    .sts_wbits (wr_placed[NUM_TIMERS-1:0]),
    .sts_wmask (wr_mask[NUM_TIMERS-1:0]),
    .ch_hit    (ch_hit),
    .cfg       (cfg),
    .status    (irq_status),
    .en_rise   (en_rise),
    .en_fall   (en_fall),
    .w1c_bits  (w1c_bits)
  );

  assign cnt_run      = cfg[0];
  assign legacy_route = cfg[1];

  evt_main_counter #(.CW(64)) cnt_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (cfg[0]),
    .tick_en (tick_en),
    .en_rise (en_rise),
    .en_fall (en_fall),
    .wr_en   (cnt_wr_evt),
    .wdata   (wr_placed),
    .wmask   (wr_mask),
    .value   (main_count)
  );

  // Channel steering.
  generate
    for (genvar n = 0; n < NUM_TIMERS; n++) begin : g_sel
      assign ch_sel[n] = acc_valid && (tgt == TGT_CHAN) && (dec_idx == 5'(n));
    end
  endgenerate

  assign ch_reg   = dec_reg;
  assign ch_we    = acc_valid && acc_write && (tgt == TGT_CHAN);
  assign ch_wdata = wr_placed;
  assign ch_wmask = wr_mask;

  logic [63:0] ch_word;
  always_comb begin
    ch_word = '0;
    for (int n = 0; n < NUM_TIMERS; n++) begin
      if (ch_sel[n]) ch_word = ch_rdata[n*64 +: 64];
    end
  end

  logic [63:0] raw_read;
  always_comb begin
    unique case (tgt)
      TGT_CAP:  raw_read = CAP_VALUE;
      TGT_CFG:  raw_read = {62'h0, cfg};
      TGT_STS:  raw_read = 64'(irq_status);
      TGT_CNT:  raw_read = main_count;
      TGT_CHAN: raw_read = ch_word;
      default:  raw_read = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= acc_valid && !acc_write;
      if (acc_valid && !acc_write) rd_data <= lane_extract(raw_read, hi_half, wide);
    end
  end
endmodule

// File: rtl/evt_regs_chk.sv
module evt_regs_chk #(
  parameter int NUM_TIMERS = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  tick_en,
  input logic                  acc_valid,
  input logic                  acc_write,
  input logic                  rd_valid,
  input logic [NUM_TIMERS-1:0] ch_sel,
  input logic [NUM_TIMERS-1:0] ch_hit,
  input logic [NUM_TIMERS-1:0] irq_status,
  input logic                  cnt_run,
  input logic [63:0]           main_count,
  input logic                  cfg_wr_evt,
  input logic                  cnt_wr_evt,
  input logic                  bad_acc,
  input logic [NUM_TIMERS-1:0] w1c_bits
);
  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write) |=> rd_valid); // R11
  AST_NO_RD_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write) |=> !rd_valid); // R11
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_run && tick_en && !cfg_wr_evt) |=> (main_count == $past(main_count) + 64'd1)); // R4
  AST_CNT_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_run && !cnt_wr_evt) |=> $stable(main_count)); // R4
  AST_CNT_RUN_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_run && !tick_en && cnt_wr_evt) |=> $stable(main_count)); // R6
  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_sel)); // R8
  AST_BAD_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    bad_acc |-> (ch_sel == '0)); // R9
  AST_HIT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (|ch_hit) |=> ((irq_status & $past(ch_hit)) == $past(ch_hit))); // R7
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ((|w1c_bits) && (ch_hit == '0)) |=> ((irq_status & $past(w1c_bits)) == '0)); // R7
endmodule

bind evt_regs evt_regs_chk #(.NUM_TIMERS(NUM_TIMERS)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick_en    (tick_en),
  .acc_valid  (acc_valid),
  .acc_write  (acc_write),
  .rd_valid   (rd_valid),
  .ch_sel     (ch_sel),
  .ch_hit     (ch_hit),
  .irq_status (irq_status),
  .cnt_run    (cnt_run),
  .main_count (main_count),
  .cfg_wr_evt (cfg_wr_evt),
  .cnt_wr_evt (cnt_wr_evt),
  .bad_acc    (bad_acc),
  .w1c_bits   (w1c_bits)
);

// File: tb/evt_regs_tb_top.sv
`timescale 1ns/1ps
module evt_regs_tb_top;
  localparam int NT = 3;
  localparam logic [63:0] EXP_CAP = {32'd10_000_000, 16'hA5C3, 16'hA201};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b0;
  logic acc_valid = 1'b0, acc_write = 1'b0;
  logic [9:0] acc_addr = '0;
  logic [1:0] acc_size = 2'b11;
  logic [63:0] acc_wdata = '0;
  logic rd_valid;
  logic [63:0] rd_data;
  logic [NT-1:0] ch_sel;
  logic [1:0] ch_reg;
  logic ch_we;
  logic [63:0] ch_wdata, ch_wmask;
  logic [NT*64-1:0] ch_rdata;
  logic [NT-1:0] ch_hit = '0;
  logic [NT-1:0] irq_status;
  logic cnt_run, legacy_route;
  logic [63:0] main_count;

  int checks = 0, failures = 0, sel_seen = 0;
  logic [63:0] chmem [NT][4];

  always #2.5 clk = ~clk;

  evt_regs #(.NUM_TIMERS(NT)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .acc_valid(acc_valid),
    .acc_write(acc_write), .acc_addr(acc_addr), .acc_size(acc_size),
    .acc_wdata(acc_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .ch_sel(ch_sel), .ch_reg(ch_reg), .ch_we(ch_we), .ch_wdata(ch_wdata),
    .ch_wmask(ch_wmask), .ch_rdata(ch_rdata), .ch_hit(ch_hit),
    .irq_status(irq_status), .cnt_run(cnt_run), .legacy_route(legacy_route),
    .main_count(main_count)
  );

  // Channel register model.
  initial begin
    for (int i = 0; i < NT; i++) for (int k = 0; k < 4; k++) chmem[i][k] = '0;
  end
  always @(posedge clk) begin
    if (|ch_sel) sel_seen <= sel_seen + 1;
    for (int i = 0; i < NT; i++)
      if (ch_sel[i] && ch_we)
        chmem[i][ch_reg] <= (ch_wdata & ch_wmask) | (chmem[i][ch_reg] & ~ch_wmask);
  end
  always_comb begin
    for (int i = 0; i < NT; i++) ch_rdata[i*64 +: 64] = chmem[i][ch_reg];
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic acc(input logic wr, input logic [9:0] a, input logic wide,
                     input logic [63:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = wr; acc_addr = a;
    acc_size = wide ? 2'b11 : 2'b10; acc_wdata = d;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, input logic wide, output logic [63:0] v);
    acc(1'b0, a, wide, 64'h0);
    check("R11 rd_valid", 64'(rd_valid), 64'd1);
    v = rd_data;
  endtask

  task automatic t_reset();
    logic [63:0] v;
    check("R10 rd_valid", 64'(rd_valid), 64'd0);
    check("R10 status", 64'(irq_status), 64'd0);
    check("R10 count", main_count, 64'd0);
    rd(10'h010, 1'b1, v); check("R10 cfg", v, 64'd0);
  endtask

  task automatic t_cap();
    logic [63:0] v;
    rd(10'h000, 1'b1, v); check("R1 cap", v, EXP_CAP);
    acc(1'b1, 10'h000, 1'b1, 64'h0);
    rd(10'h000, 1'b1, v); check("R1 cap after write", v, EXP_CAP);
    rd(10'h004, 1'b0, v); check("R3 cap upper half", v, 64'd10_000_000);
    rd(10'h000, 1'b0, v); check("R3 cap lower half", v, 64'h0000_0000_A5C3_A201);
  endtask

  task automatic t_cfg();
    logic [63:0] v;
    acc(1'b1, 10'h010, 1'b1, 64'hFFFF_FFFF_FFFF_FFFE);
    rd(10'h010, 1'b1, v); check("R2 cfg mask", v, 64'h2);
    check("R2 legacy_route", 64'(legacy_route), 64'd1);
    acc(1'b1, 10'h010, 1'b1, 64'h0);
    rd(10'h010, 1'b1, v); check("R2 cfg clear", v, 64'h0);
  endtask

  task automatic t_counter();
    logic [63:0] v;
    acc(1'b1, 10'h0F0, 1'b1, 64'hAAAA_BBBB_CCCC_DDDD);
    acc(1'b1, 10'h0F4, 1'b0, 64'hFFFF_FFFF_1111_2222);
    rd(10'h0F0, 1'b1, v); check("R6 halted load lanes", v, 64'h1111_2222_CCCC_DDDD);
    rd(10'h0F4, 1'b0, v); check("R3 counter upper half", v, 64'h1111_2222);
    tick_en = 1'b1; repeat (5) @(negedge clk); tick_en = 1'b0;
    check("R4 halted frozen", main_count, 64'h1111_2222_CCCC_DDDD);
    acc(1'b1, 10'h010, 1'b1, 64'h1);
    check("R5 resume from stored", main_count, 64'h1111_2222_CCCC_DDDD);
    tick_en = 1'b1; repeat (7) @(negedge clk); tick_en = 1'b0;
    repeat (3) @(negedge clk);
    rd(10'h0F0, 1'b1, v); check("R4 seven ticks", v, 64'h1111_2222_CCCC_DDE4);
    acc(1'b1, 10'h0F0, 1'b1, 64'h1234);
    rd(10'h0F0, 1'b1, v); check("R6 running write ignored", v, 64'h1111_2222_CCCC_DDE4);
    acc(1'b1, 10'h010, 1'b1, 64'h0);
    tick_en = 1'b1; repeat (4) @(negedge clk); tick_en = 1'b0;
    rd(10'h0F0, 1'b1, v); check("R5 freeze on disable", v, 64'h1111_2222_CCCC_DDE4);
  endtask

  task automatic t_status();
    logic [63:0] v;
    @(negedge clk); ch_hit = 3'b111; @(negedge clk); ch_hit = 3'b000;
    check("R7 hit sets", 64'(irq_status), 64'h7);
    acc(1'b1, 10'h020, 1'b1, 64'h0);
    check("R7 zero write no effect", 64'(irq_status), 64'h7);
    acc(1'b1, 10'h020, 1'b1, 64'h2);
    check("R7 w1c single bit", 64'(irq_status), 64'h5);
    acc(1'b1, 10'h024, 1'b0, 64'h5);
    check("R3 upper half w1c no effect", 64'(irq_status), 64'h5);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b1; acc_addr = 10'h020; acc_size = 2'b11;
    acc_wdata = 64'h5; ch_hit = 3'b001;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0; ch_hit = 3'b000;
    check("R7 hit beats clear", 64'(irq_status), 64'h1);
    rd(10'h020, 1'b1, v); check("R7 status read", v, 64'h1);
  endtask

  task automatic t_channels();
    logic [63:0] v;
    acc(1'b1, 10'h148, 1'b1, 64'hDEAD_BEEF_0123_4567);
    check("R8 comparator write", chmem[2][1], 64'hDEAD_BEEF_0123_4567);
    rd(10'h148, 1'b1, v); check("R8 comparator read", v, 64'hDEAD_BEEF_0123_4567);
    acc(1'b1, 10'h124, 1'b0, 64'h0000_0000_CAFE_F00D);
    acc(1'b1, 10'h120, 1'b0, 64'hFFFF_FFFF_0000_0044);
    rd(10'h120, 1'b1, v); check("R8 R3 config lanes", v, 64'hCAFE_F00D_0000_0044);
    acc(1'b1, 10'h110, 1'b1, 64'h77);
    rd(10'h110, 1'b1, v); check("R8 route read", v, 64'h77);
  endtask

  task automatic t_ignored();
    logic [63:0] v;
    int s0;
    s0 = sel_seen;
    acc(1'b1, 10'h168, 1'b1, 64'h99);
    rd(10'h168, 1'b1, v); check("R9 index out of range reads 0", v, 64'h0);
    acc(1'b1, 10'h118, 1'b1, 64'h99);
    rd(10'h118, 1'b1, v); check("R9 reserved code reads 0", v, 64'h0);
    check("R9 no channel select", 64'(sel_seen - s0), 64'd0);
    acc(1'b1, 10'h030, 1'b1, 64'h3);
    acc(1'b1, 10'h011, 1'b1, 64'h3);
    rd(10'h010, 1'b1, v); check("R9 cfg untouched", v, 64'h0);
    rd(10'h008, 1'b1, v); check("R9 unknown reads 0", v, 64'h0);
    rd(10'h0F2, 1'b1, v); check("R9 misaligned reads 0", v, 64'h0);
  endtask

  initial begin
    #(5.0 * 100000);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cap();
    t_cfg();
    t_counter();
    t_status();
    t_channels();
    t_ignored();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule